// File: doc/BRIEF.md
# 16-bit Output Compare Channel with Shadow Register

This block is one compare channel of a 16-bit timer/counter that an 8-bit CPU bus reaches. Software loads a 16-bit compare value in two byte writes. The high byte waits in a staging register, and the low-byte write moves both halves at once, so the comparator never sees a half-updated value. The counter, the TOP and BOTTOM event strobes and the waveform-mode code come from the surrounding timer. The match pulse feeds the waveform generator, and the flag feeds the interrupt controller.

In the PWM waveform modes the value first lands in a shadow register. It becomes the active compare value only on the update event of the counting sequence, which keeps every PWM period whole and symmetric. In the normal and clear-on-match modes, writes go straight to the active register. A force strobe can raise a match on the output path without touching the flag.

Top module: `oc16_unit`

## Requirements
- R1: Buffering is off for mode codes 0 (normal), 4 and 12 (clear-on-match). Every other 4-bit mode code is a PWM mode with buffering on.
- R2: With buffering on, a low-byte write (address 0) loads the shadow register with {staging, data}. The active compare value is left unchanged.
- R3: With buffering on, the shadow is copied to the active register at the clock edge where the update strobe is high. In modes 8 and 9 the update strobe is the BOTTOM strobe, and in every other PWM mode it is the TOP strobe. The other strobe has no effect.
- R4: With buffering off, a low-byte write loads the active register with {staging, data} in one clock edge, so all 16 bits change together.
- R5: A high-byte write (address 1) only loads the 8-bit staging register. The shadow, the active value and the values read back do not change.
- R6: The counter is compared with the active register on every cycle. When they are equal at a clock edge, match_o is high for the following cycle.
- R7: A real match sets a sticky flag, seen on flag_o and irq_o. The flag clears only when a one is written to bit 0 of address 2. Writing zero there has no effect, and a match in the same cycle as the clear wins.
- R8: In a non-PWM mode, force_i raises match_o in the next cycle, just as a real match would, and leaves the flag unchanged.
- R9: In a PWM mode, force_i is ignored, and match_o stays low unless there is a real match.
- R10: Reads are combinational. Address 0 returns the low byte and address 1 the high byte, taken from the shadow when buffering is on and from the active register when it is off. Address 2 returns the flag in bit 0.
- R11: Reset sets the staging, shadow and active registers and the flag to zero, and match_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Waveform-mode code |
| cnt_i | input | 16 | Timer counter value |
| top_evt_i | input | 1 | Counter reached TOP |
| bottom_evt_i | input | 1 | Counter reached BOTTOM |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 2 | Write address: 0 low, 1 high, 2 flag |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data |
| force_i | input | 1 | Force-compare strobe |
| match_o | output | 1 | Match pulse to waveform path |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A table of vectors writes compare values across normal, clear-on-match, TOP-updated PWM and BOTTOM-updated PWM modes, including the all-zero and all-ones values. Each value is paired with a counter that is either equal or off by one bit, so an exact-match compare can be told apart from a partial or loose one. Directed sequences then place each update strobe separately after a shadowed write and probe the active value by its match behaviour. This separates the TOP-update modes from the BOTTOM-update modes and shows that a high-byte write on its own stages nothing visible. Force strobes are applied in both mode classes, and flag clears are applied with zero and with one.

// File: rtl/oc16_pkg.sv
package oc16_pkg;
  localparam int MODE_W = 4;

  localparam logic [1:0] ADDR_LO  = 2'd0;
  localparam logic [1:0] ADDR_HI  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

  // buffering is off only in the normal and clear-on-match modes
  function automatic logic mode_buffered(input logic [MODE_W-1:0] m);
    return !(m == 4'd0 || m == 4'd4 || m == 4'd12);
  endfunction

  // the phase-and-frequency style modes take the new value at BOTTOM
  function automatic logic mode_upd_bottom(input logic [MODE_W-1:0] m);
    return (m == 4'd8 || m == 4'd9);
  endfunction
endpackage

// File: rtl/oc16_mode_dec.sv
module oc16_mode_dec
  import oc16_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              top_evt_i,
  input  logic              bottom_evt_i,
  output logic              buffered_o,
  output logic              commit_o
);
  logic at_bottom;

  always_comb begin
    buffered_o = mode_buffered(mode_i);
    at_bottom  = mode_upd_bottom(mode_i);
    commit_o   = buffered_o && (at_bottom ? bottom_evt_i : top_evt_i);
  end
endmodule

// File: rtl/oc16_regs.sv
module oc16_regs #(
  parameter int BYTE_W = 8,
  localparam int VAL_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              buffered_i,
  input  logic              commit_i,
  output logic [VAL_W-1:0]  active_o,
  output logic [VAL_W-1:0]  shadow_o,
  output logic [BYTE_W-1:0] stage_o
);
  function automatic logic [VAL_W-1:0] cat_bytes(input logic [BYTE_W-1:0] hi,
                                                 input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  logic [BYTE_W-1:0] stage_q;
  logic [VAL_W-1:0]  shadow_q, active_q;
  logic [VAL_W-1:0]  wr_word;
  logic              ld_shadow, ld_active_direct;

  always_comb begin
    wr_word          = cat_bytes(stage_q, wr_data_i);
    ld_shadow        = wr_lo_i && buffered_i;
    ld_active_direct = wr_lo_i && !buffered_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_hi_i) stage_q <= wr_data_i;
      if (ld_shadow) shadow_q <= wr_word;
      if (ld_active_direct) active_q <= wr_word;
      else if (commit_i) active_q <= shadow_q;
    end
  end

  assign active_o = active_q;
  assign shadow_o = shadow_q;
  assign stage_o  = stage_q;

  // R5
  stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_i && !wr_lo_i && !commit_i) |=> ($stable(active_q) && $stable(shadow_q)));

  // R4
  atomic_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i && !buffered_i) |=> (active_q == {$past(stage_q), $past(wr_data_i)}));

  // R2
  shadow_hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i && buffered_i && !commit_i) |=> $stable(active_q));

  // R3
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !wr_lo_i) |=> (active_q == $past(shadow_q)));
endmodule

// File: rtl/oc16_match.sv
module oc16_match #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] cnt_i,
  input  logic [VAL_W-1:0] active_i,
  input  logic             force_i,
  input  logic             buffered_i,
  input  logic             flag_clr_i,
  output logic             hit_o,
  output logic             force_ok_o,
  output logic             match_o,
  output logic             flag_o
);
  logic match_q, flag_q;

  always_comb begin
    hit_o      = (cnt_i == active_i);
    force_ok_o = force_i && !buffered_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      match_q <= hit_o || force_ok_o;
      if (hit_o) flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign match_o = match_q;
  assign flag_o  = flag_q;

  // R6
  hit_to_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> (match_o && flag_o));

  // R8
  force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ok_o && !hit_o && !flag_o) |=> !flag_o);

  // R9
  force_pwm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i && buffered_i && !hit_o) |=> !match_o);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);
endmodule

// File: rtl/oc16_unit.sv
module oc16_unit
  import oc16_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int VAL_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [VAL_W-1:0]  cnt_i,
  input  logic              top_evt_i,
  input  logic              bottom_evt_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              force_i,
  output logic              match_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic              buffered, commit;
  logic              wr_lo, wr_hi, flag_clr;
  logic [VAL_W-1:0]  active, shadow, view;
  logic [BYTE_W-1:0] stage;
  logic              hit, force_ok;

  always_comb begin
    wr_lo    = wr_en_i && (wr_addr_i == ADDR_LO);
    wr_hi    = wr_en_i && (wr_addr_i == ADDR_HI);
    flag_clr = wr_en_i && (wr_addr_i == ADDR_CTL) && wr_data_i[0];
  end

  oc16_mode_dec u_dec (
    .mode_i       (mode_i),
    .top_evt_i    (top_evt_i),
    .bottom_evt_i (bottom_evt_i),
    .buffered_o   (buffered),
    .commit_o     (commit)
  );

  oc16_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lo_i    (wr_lo),
    .wr_hi_i    (wr_hi),
    .wr_data_i  (wr_data_i),
    .buffered_i (buffered),
    .commit_i   (commit),
    .active_o   (active),
    .shadow_o   (shadow),
    .stage_o    (stage)
  );

  oc16_match #(.VAL_W(VAL_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt_i),
    .active_i   (active),
    .force_i    (force_i),
    .buffered_i (buffered),
    .flag_clr_i (flag_clr),
    .hit_o      (hit),
    .force_ok_o (force_ok),
    .match_o    (match_o),
    .flag_o     (flag_o)
  );

  // R10 read view follows the write target of the current mode
  always_comb begin
    view = buffered ? shadow : active;
    unique case (rd_addr_i)
      ADDR_LO:  rd_data_o = view[BYTE_W-1:0];
      ADDR_HI:  rd_data_o = view[VAL_W-1:BYTE_W];
      ADDR_CTL: rd_data_o = {{(BYTE_W-1){1'b0}}, flag_o};
      default:  rd_data_o = '0;
    endcase
  end

  assign irq_o = flag_o;

  // R1
  unbuffered_modes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'd0 || mode_i == 4'd4 || mode_i == 4'd12) |-> !commit);

  // R7
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == flag_o);

  // R5 staging byte is never visible on reads
  stage_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && rd_addr_i == ADDR_HI && !commit && !wr_lo) |=> $stable(rd_data_o) || $changed(mode_i) || $changed(rd_addr_i));

  logic unused_stage;
  assign unused_stage = ^stage ^ force_ok;
endmodule

// File: tb/oc16_unit_tb_top.sv
module oc16_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_i = 4'd0;
  logic [15:0] cnt_i = 16'hFFFF;
  logic        top_evt_i = 1'b0, bottom_evt_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [7:0]  wr_data_i = 8'd0;
  logic [1:0]  rd_addr_i = 2'd0;
  logic [7:0]  rd_data_o;
  logic        force_i = 1'b0;
  logic        match_o, flag_o, irq_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  oc16_unit dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cnt_i(cnt_i),
    .top_evt_i(top_evt_i), .bottom_evt_i(bottom_evt_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .force_i(force_i),
    .match_o(match_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  // {mode, value, counter, expected match}
  localparam int NV = 8;
  localparam logic [36:0] VEC [NV] = '{
    {4'd0,  16'h1234, 16'h1234, 1'b1},
    {4'd0,  16'h1234, 16'h1235, 1'b0},
    {4'd4,  16'hFFFF, 16'hFFFF, 1'b1},
    {4'd12, 16'h0000, 16'h0000, 1'b1},
    {4'd14, 16'h8001, 16'h8001, 1'b1},
    {4'd14, 16'h8001, 16'h0001, 1'b0},
    {4'd8,  16'h00FF, 16'h00FF, 1'b1},
    {4'd1,  16'hA5A5, 16'hA5A4, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    rd_addr_i = 2'd0; #1 v[7:0] = rd_data_o;
    rd_addr_i = 2'd1; #1 v[15:8] = rd_data_o;
  endtask

  task automatic do_reset();
    cnt_i = 16'hFFFF; mode_i = 4'd0;
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic pulse(input logic top, input logic bot);
    top_evt_i = top; bottom_evt_i = bot;
    step();
    top_evt_i = 1'b0; bottom_evt_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);
    do_reset();
    // R11 reset state
    rd16(v); check("R11 value", v, 16'h0000);
    check("R11 flag", {15'd0, flag_o}, 16'd0);
    check("R11 match", {15'd0, match_o}, 16'd0);
    mode_i = 4'd14; rd16(v); check("R11 shadow", v, 16'h0000);
    mode_i = 4'd0;

    // R6 / R1 / R4 vector table
    for (int i = 0; i < NV; i++) begin
      logic [3:0] m; logic [15:0] val, cv; logic e;
      {m, val, cv, e} = VEC[i];
      mode_i = m;
      cnt_i = ~val;
      bus_wr(2'd1, val[15:8]);
      bus_wr(2'd0, val[7:0]);
      if (!(m == 4'd0 || m == 4'd4 || m == 4'd12)) pulse(1'b1, 1'b1);
      cnt_i = cv;
      step();
      check($sformatf("R6 vector %0d", i), {15'd0, match_o}, {15'd0, e});
    end

    // R5 / R4 / R7 directed, normal mode
    do_reset();
    bus_wr(2'd1, 8'hAB);
    rd16(v); check("R5 hi write hidden", v, 16'h0000);
    bus_wr(2'd0, 8'hCD);
    rd16(v); check("R4 direct load", v, 16'hABCD);
    cnt_i = 16'hABCD; step();
    check("R6 match", {15'd0, match_o}, 16'd1);
    check("R7 flag set", {14'd0, flag_o, irq_o}, 16'd3);
    cnt_i = 16'h0000; step();
    check("R7 sticky", {15'd0, flag_o}, 16'd1);
    check("R6 no match", {15'd0, match_o}, 16'd0);
    bus_wr(2'd2, 8'h00);
    check("R7 write zero", {15'd0, flag_o}, 16'd1);
    rd_addr_i = 2'd2; #1 check("R10 flag read", {8'd0, rd_data_o}, 16'h0001);
    bus_wr(2'd2, 8'h01);
    check("R7 cleared", {14'd0, flag_o, irq_o}, 16'd0);
    // clear while a real match occurs: set wins
    cnt_i = 16'hABCD;
    bus_wr(2'd2, 8'h01);
    check("R7 set beats clear", {15'd0, flag_o}, 16'd1);
    cnt_i = 16'h0000; step();
    bus_wr(2'd2, 8'h01);

    // R8 force in normal mode
    force_i = 1'b1; step(); force_i = 1'b0;
    check("R8 force match", {15'd0, match_o}, 16'd1);
    check("R8 flag untouched", {15'd0, flag_o}, 16'd0);
    step();
    check("R8 single pulse", {15'd0, match_o}, 16'd0);

    // R2 / R3 / R9 TOP-updated PWM mode
    mode_i = 4'd14;
    rd16(v); check("R10 shadow view", v, 16'h0000);
    bus_wr(2'd1, 8'h12);
    bus_wr(2'd0, 8'h34);
    rd16(v); check("R2 shadow load", v, 16'h1234);
    cnt_i = 16'hABCD; step();
    check("R2 active kept", {15'd0, match_o}, 16'd1);
    cnt_i = 16'h1234; step();
    check("R2 not yet active", {15'd0, match_o}, 16'd0);
    pulse(1'b0, 1'b1); step();
    check("R3 bottom ignored", {15'd0, match_o}, 16'd0);
    pulse(1'b1, 1'b0); step();
    check("R3 top commit", {15'd0, match_o}, 16'd1);
    cnt_i = 16'h0000; step();
    force_i = 1'b1; step(); force_i = 1'b0;
    check("R9 force ignored", {15'd0, match_o}, 16'd0);
    mode_i = 4'd0;
    rd16(v); check("R10 active view", v, 16'h1234);

    // R3 BOTTOM-updated mode
    mode_i = 4'd8;
    bus_wr(2'd1, 8'h56);
    bus_wr(2'd0, 8'h78);
    cnt_i = 16'h5678;
    pulse(1'b1, 1'b0); step();
    check("R3 top ignored mode 8", {15'd0, match_o}, 16'd0);
    pulse(1'b0, 1'b1); step();
    check("R3 bottom commit mode 8", {15'd0, match_o}, 16'd1);

    // R11 reset clears everything again
    do_reset();
    rd16(v); check("R11 after use", v, 16'h0000);
    check("R11 flag after use", {15'd0, flag_o}, 16'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule